// File: doc/BRIEF.md
# Delayed-Transfer PC Sequencer with Slot Squash

This block keeps the fetch address pair of an in-order core whose control transfers are delayed. It holds a current PC and a next-PC, so the instruction that sits right after a transfer in program order (the delay-slot instruction) is always issued before the target takes effect. On each issue step the PC takes the old next-PC. The next-PC takes either the resolved target or its sequential successor.

The block also decides whether the delay-slot instruction is squashed. The decision depends on the annul bit of the resolving transfer, on whether the transfer is conditional, and on whether it was taken. A squashed slot still uses its issue step and moves the PC forward, but it has no effects. This includes any transfer it might claim to resolve. The squash mark lasts for that one slot only.

The pipeline drives `step_i` whenever an instruction leaves the issue point. In the same cycle it raises `xfer_vld_i` if that instruction is a resolved control transfer.

Top module: `dbr_seq`

## Requirements
- R1: While reset is asserted and after it is released, before any step, `pc_o` equals the parameter RESET_VEC, `npc_o` equals RESET_VEC+STEP (STEP defaults to 4), and `squash_o` is 0.
- R2: In a cycle with `step_i` low, `pc_o`, `npc_o` and `squash_o` keep their values, whatever the transfer inputs carry.
- R3: On a step, `pc_o` takes the value `npc_o` had before the step.
- R4: On a step with a taken transfer (`xfer_vld_i`=1, `xfer_taken_i`=1) from an unsquashed slot, `npc_o` takes `xfer_tgt_i`. The target therefore reaches `pc_o` one step after the delay slot.
- R5: On a step without a valid transfer, or with a not-taken one, `npc_o` becomes its previous value plus STEP.
- R6: A conditional transfer (`xfer_cond_i`=1) with the annul bit set (`xfer_annul_i`=1) sets `squash_o` for the delay slot exactly when it is not taken.
- R7: An unconditional transfer (`xfer_cond_i`=0) with the annul bit set sets `squash_o` for the delay slot whether or not it is taken.
- R8: A transfer with the annul bit clear never sets `squash_o`.
- R9: `squash_o` drops on the step that follows the squashed slot, unless that step itself resolves an annulling transfer from an unsquashed slot.
- R10: A transfer presented on a step while `squash_o` is 1 is ignored. There is no redirect, `npc_o` advances by STEP, and `squash_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | The instruction at `pc_o` issues this cycle |
| xfer_vld_i | input | 1 | The issuing instruction is a resolved control transfer |
| xfer_taken_i | input | 1 | The transfer is taken |
| xfer_cond_i | input | 1 | The transfer is conditional (0: unconditional) |
| xfer_annul_i | input | 1 | Annul bit of the transfer |
| xfer_tgt_i | input | AW | Resolved target address |
| pc_o | output | AW | Address of the instruction at the issue point |
| npc_o | output | AW | Address that follows `pc_o` |
| squash_o | output | 1 | The instruction at `pc_o` is a squashed delay slot |

## Verification
The properties assume that every transfer input holds a known value at each rising edge and is read only in that edge's cycle. They also assume that `xfer_vld_i` refers to the instruction issuing under `step_i`. They make no assumption about target alignment, and they do not tie the strobes together, because the design must itself ignore transfer inputs without a step or in a squashed slot. The bench changes all inputs on the falling edge and holds them across the rising edge. Its directed and pseudo-random phases deliberately raise the transfer strobes without a step and during squashed slots. They also cover every combination of the conditional, taken and annul bits.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    // Kind of transfer that takes effect on an issue step.
    typedef enum logic [1:0] {
        XFER_NONE   = 2'd0,
        XFER_COND   = 2'd1,
        XFER_UNCOND = 2'd2
    } xfer_kind_e;

    // Slot-squash rule: a conditional transfer kills its delay slot only
    // when it falls through; an unconditional one kills it always.
    // Both require the annul bit.
    function automatic logic slot_squashed(xfer_kind_e kind, logic taken, logic annul);
        case (kind)
            XFER_COND:   return annul & ~taken;
            XFER_UNCOND: return annul;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbr_xfer_decode.sv
module dbr_xfer_decode
    import dbr_pkg::*;
(
    input  logic step_i,
    input  logic vld_i,
    input  logic taken_i,
    input  logic cond_i,
    input  logic annul_i,
    input  logic cur_squash_i,
    output logic redirect_o,
    output logic squash_next_o
);

    xfer_kind_e kind;

    always_comb begin
        // A squashed slot has no effects, so its transfer is dropped.
        if (!step_i || !vld_i || cur_squash_i) begin
            kind = XFER_NONE;
        end else if (cond_i) begin
            kind = XFER_COND;
        end else begin
            kind = XFER_UNCOND;
        end
        redirect_o    = (kind != XFER_NONE) && taken_i;
        squash_next_o = slot_squashed(kind, taken_i, annul_i);
    end

endmodule

// File: rtl/dbr_npc_gen.sv
module dbr_npc_gen #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] npc_i,
    input  logic [AW-1:0] tgt_i,
    input  logic          redirect_i,
    output logic [AW-1:0] npc_next_o
);

    localparam logic [AW-1:0] INCR = AW'(STEP);

    logic [AW-1:0] npc_seq;

    always_comb begin
        npc_seq    = npc_i + INCR;
        npc_next_o = redirect_i ? tgt_i : npc_seq;
    end

endmodule

// File: rtl/dbr_seq.sv
module dbr_seq #(
    parameter int              AW        = 32,
    parameter int              STEP      = 4,
    parameter logic [AW-1:0]   RESET_VEC = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          xfer_vld_i,
    input  logic          xfer_taken_i,
    input  logic          xfer_cond_i,
    input  logic          xfer_annul_i,
    input  logic [AW-1:0] xfer_tgt_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] npc_o,
    output logic          squash_o
);

    localparam logic [AW-1:0] RESET_NPC = RESET_VEC + AW'(STEP);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] npc;
        logic          squash;
    } seq_state_t;

    seq_state_t    st_d, st_q;
    logic          redirect;
    logic          squash_next;
    logic [AW-1:0] npc_next;

    dbr_xfer_decode i_decode (
        .step_i        (step_i),
        .vld_i         (xfer_vld_i),
        .taken_i       (xfer_taken_i),
        .cond_i        (xfer_cond_i),
        .annul_i       (xfer_annul_i),
        .cur_squash_i  (st_q.squash),
        .redirect_o    (redirect),
        .squash_next_o (squash_next)
    );

    dbr_npc_gen #(
        .AW   (AW),
        .STEP (STEP)
    ) i_npc (
        .npc_i      (st_q.npc),
        .tgt_i      (xfer_tgt_i),
        .redirect_i (redirect),
        .npc_next_o (npc_next)
    );

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.pc     = st_q.npc;
            st_d.npc    = npc_next;
            st_d.squash = squash_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc     <= RESET_VEC;
            st_q.npc    <= RESET_NPC;
            st_q.squash <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o     = st_q.pc;
    assign npc_o    = st_q.npc;
    assign squash_o = st_q.squash;

endmodule

// File: rtl/dbr_seq_chk.sv
module dbr_seq_chk #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_i,
    input logic          xfer_vld_i,
    input logic          xfer_taken_i,
    input logic          xfer_cond_i,
    input logic          xfer_annul_i,
    input logic [AW-1:0] xfer_tgt_i,
    input logic [AW-1:0] pc_o,
    input logic [AW-1:0] npc_o,
    input logic          squash_o
);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(squash_o)));

    p_pc_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (pc_o == $past(npc_o)));

    p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && xfer_vld_i && xfer_taken_i && !squash_o) |=> (npc_o == $past(xfer_tgt_i)));

    p_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (!xfer_vld_i || !xfer_taken_i || squash_o))
        |=> (npc_o == $past(npc_o) + AW'(STEP)));

    p_cond_annul_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && xfer_vld_i && !squash_o && xfer_cond_i && xfer_annul_i)
        |=> (squash_o == !$past(xfer_taken_i)));

    p_uncond_annul_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && xfer_vld_i && !squash_o && !xfer_cond_i && xfer_annul_i) |=> squash_o);

    // R8, R9 and R10: only an annulling transfer from a live slot may squash.
    p_no_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !(xfer_vld_i && xfer_annul_i && !squash_o)) |=> !squash_o);

    p_squash_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && squash_o) |=> !squash_o);

endmodule

bind dbr_seq dbr_seq_chk #(
    .AW   (AW),
    .STEP (STEP)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .xfer_vld_i   (xfer_vld_i),
    .xfer_taken_i (xfer_taken_i),
    .xfer_cond_i  (xfer_cond_i),
    .xfer_annul_i (xfer_annul_i),
    .xfer_tgt_i   (xfer_tgt_i),
    .pc_o         (pc_o),
    .npc_o        (npc_o),
    .squash_o     (squash_o)
);

// File: tb/test_dbr_seq.sv
`timescale 1ns/100ps
module test_dbr_seq;

    localparam int          AW  = 32;
    localparam logic [31:0] VEC = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_i = 1'b0;
    logic          xfer_vld_i = 1'b0;
    logic          xfer_taken_i = 1'b0;
    logic          xfer_cond_i = 1'b0;
    logic          xfer_annul_i = 1'b0;
    logic [AW-1:0] xfer_tgt_i = '0;
    logic [AW-1:0] pc_o, npc_o;
    logic          squash_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference state.
    logic [31:0] m_pc, m_npc;
    logic        m_sq;

    always #2.5 clk = ~clk;

    dbr_seq i_dbr_seq (
        .clk(clk), .rst_n(rst_n), .step_i(step_i),
        .xfer_vld_i(xfer_vld_i), .xfer_taken_i(xfer_taken_i),
        .xfer_cond_i(xfer_cond_i), .xfer_annul_i(xfer_annul_i),
        .xfer_tgt_i(xfer_tgt_i), .pc_o(pc_o), .npc_o(npc_o), .squash_o(squash_o)
    );

    task automatic compare(string tag);
        checks++;
        if (pc_o !== m_pc || npc_o !== m_npc || squash_o !== m_sq) begin
            fails++;
            $display("FAIL %s: pc/npc/squash actual %h/%h/%b expected %h/%h/%b",
                     tag, pc_o, npc_o, squash_o, m_pc, m_npc, m_sq);
        end
    endtask

    // Drive one cycle on the falling edge, update the model at the rising
    // edge, and compare after it has settled.
    task automatic cyc(bit st, bit vld, bit tk, bit cnd, bit an, logic [31:0] tgt, string tag);
        bit live;
        @(negedge clk);
        step_i = st; xfer_vld_i = vld; xfer_taken_i = tk;
        xfer_cond_i = cnd; xfer_annul_i = an; xfer_tgt_i = tgt;
        @(posedge clk);
        if (st) begin
            live  = vld && !m_sq;
            m_pc  = m_npc;
            m_npc = (live && tk) ? tgt : m_npc + 32'd4;
            if (live && an) m_sq = cnd ? !tk : 1'b1;
            else            m_sq = 1'b0;
        end
        #1;
        compare(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        m_pc = VEC; m_npc = VEC + 32'd4; m_sq = 1'b0;
        repeat (3) @(posedge clk);
        #1 compare("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 compare("R1 after release");

        cyc(0, 1, 1, 0, 1, 32'h0000_9000, "R2 strobe without step");
        cyc(0, 0, 0, 0, 0, 32'h0, "R2 idle");
        cyc(1, 0, 0, 0, 0, 32'h0, "R3 plain step");
        cyc(1, 1, 1, 1, 0, 32'h0000_2000, "R4 R8 taken cond no annul");
        cyc(1, 0, 0, 0, 0, 32'h0, "R4 target reaches pc");
        cyc(1, 1, 0, 1, 1, 32'h0000_7000, "R6 cond annul not taken");
        cyc(1, 1, 1, 0, 1, 32'h0000_3000, "R10 transfer in squashed slot");
        cyc(1, 1, 1, 1, 1, 32'h0000_3000, "R6 cond annul taken");
        cyc(1, 0, 0, 0, 0, 32'h0, "R4 slot before target");
        cyc(1, 1, 1, 0, 1, 32'h0000_4000, "R7 uncond annul taken");
        cyc(0, 1, 0, 1, 1, 32'h0000_5000, "R2 hold while squashed");
        cyc(1, 0, 0, 0, 0, 32'h0, "R9 squash clears");
        cyc(1, 1, 0, 0, 1, 32'h0000_5000, "R7 uncond annul not taken");
        cyc(1, 1, 0, 1, 1, 32'h0000_6000, "R10 R9 squashed slot transfer");
        cyc(1, 1, 0, 1, 0, 32'h0000_6000, "R5 R8 not taken no annul");
        cyc(1, 1, 1, 0, 0, 32'h0000_8000, "R8 uncond no annul");

        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[1], lfsr[2], lfsr[3], lfsr[4], lfsr[5],
                {16'h0, lfsr[15:6], 2'b00} + 32'h0001_0000,
                "R3 R4 R5 R6 R7 R8 R9 R10 mixed");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule